// File: doc/BRIEF.md
# I2C Line Monitor and Bus Recovery Unit

This unit sits between an I2C protocol engine and the open-drain SCL and SDA pads. In normal operation it passes the engine's drive requests straight to the pad output enables. Software can take the bus away from the engine through a two-bit control register. It can then hold SCL low or release it by hand, and it can read back both the levels the unit is driving and the levels present on the wires. The wire levels pass through a synchronizer before they are reported.

Software can use the unit in two ways to free a slave that holds SDA low. It can toggle the SCL release bit itself and watch the sampled SDA bit. It can also start the built-in pulse generator, which clocks SCL with a fixed half period until SDA is sampled high or a pulse limit is reached. A forced-reset command clears the engine's protocol state with a one-cycle pulse and takes the bus from the engine before any recovery starts. Handing the bus back needs both control bits written as 1.

Top module: `busrec_unit`

## Requirements
- R1: After reset the control register reads 2'b11 (normal operation). `engClear` and `autoBusy` are 0, and the sampled-level monitor bits read 1.
- R2: With control 2'b11 and no recovery running, `sclOe` equals the inverse of `engSclDrive` and `sdaOe` equals the inverse of `engSdaDrive`. A drive value of 1 means release, and an output enable of 1 pulls the line low.
- R3: Whenever the control value is not 2'b11, the engine's drive requests have no effect and SDA is released (`sdaOe` = 0).
- R4: Control bit 0 is the SCL release bit. When it is 0 and no recovery is running, SCL is pulled low (`sclOe` = 1) whatever bit 1 holds.
- R5: Control 2'b01 (bit 1, the normal-operation enable, cleared; SCL release set) releases SCL and ignores `engSclDrive`.
- R6: Monitor bit 3 reads 1 when SDA is released and 0 when it is driven low. Monitor bit 1 reads the same way for SCL.
- R7: Monitor bit 2 reports the SDA pad level and bit 0 the SCL pad level, each delayed by exactly two clock edges.
- R8: A `rstCmd` pulse raises `engClear` for exactly the next cycle. It sets the control register to 2'b01, overrides a write in the same cycle, and stops any recovery in progress.
- R9: `autoGo` is accepted only when control bit 1 is 0 and no recovery is running. Otherwise it is ignored.
- R10: If sampled SDA is already high when `autoGo` is accepted, no SCL pulse is generated.
- R11: Each generated pulse holds SCL low for HALF_CYC cycles and then releases it for HALF_CYC cycles. Recovery ends after the first pulse at whose end sampled SDA is high, and SCL is left released.
- R12: Recovery stops after MAX_PULSES pulses even if SDA stays low.
- R13: While recovery runs, SDA is released and the generator alone controls SCL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 2 | Control write value: bit 1 normal-operation enable, bit 0 SCL release |
| rstCmd | input | 1 | Forced engine reset command |
| autoGo | input | 1 | Start automatic recovery pulses |
| engSclDrive | input | 1 | Engine SCL request (1 = release) |
| engSdaDrive | input | 1 | Engine SDA request (1 = release) |
| sclPadIn | input | 1 | SCL pad level |
| sdaPadIn | input | 1 | SDA pad level |
| sclOe | output | 1 | SCL pull-low enable |
| sdaOe | output | 1 | SDA pull-low enable |
| monData | output | 4 | Line monitor: {SDA driven, SDA sampled, SCL driven, SCL sampled} |
| ctlRd | output | 2 | Control register readback |
| engClear | output | 1 | One-cycle engine protocol clear |
| autoBusy | output | 1 | Automatic recovery in progress |

## Verification
The bench drives a modelled slave that holds SDA low until it has seen a chosen number of SCL rising edges. It checks that the generator stops on exactly that pulse, that each low phase lasts HALF_CYC cycles, and that the run caps at MAX_PULSES. A design that samples SDA at the wrong point would clock one extra pulse or stop one pulse early. A design without the cap would leave the bus clocking forever. Randomised control values and engine requests expose a mux that lets the engine through while bit 1 is cleared, or that leaves SDA driven. Checking the monitor against pad history from exactly two edges earlier catches a synchronizer that is one stage too short or too long. Directed cases cover `autoGo` while the engine owns the bus, `autoGo` when SDA is already high, and `rstCmd` in the middle of a run, where a wrong design would keep pulsing.

// File: rtl/busrec_pkg.sv
package busrec_pkg;
  typedef struct packed {
    logic engOwn;
    logic sclRel;
  } lineCtl_t;

  typedef enum logic [1:0] {
    AR_IDLE = 2'd0,
    AR_LOW  = 2'd1,
    AR_HIGH = 2'd2
  } arState_t;
endpackage

// File: rtl/busrec_ctl.sv
module busrec_ctl
  import busrec_pkg::*;
#(
  parameter int HALF_CYC   = 4,
  parameter int MAX_PULSES = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic [1:0] ctlWrData,
  input  logic       rstCmd,
  input  logic       autoGo,
  input  logic       sdaSync,
  output lineCtl_t   lineCtl,
  output logic [1:0] ctlRd,
  output logic       engClear,
  output logic       autoBusy
);
  localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(MAX_PULSES - 1);

  logic [1:0] ctlReg;
  arState_t   state;
  logic [CW-1:0] phaseCnt;
  logic [PW-1:0] pulseCnt;
  logic       goOk;
  logic       phaseEnd;

  assign goOk     = autoGo && !ctlReg[1] && (state == AR_IDLE) && !rstCmd;
  assign phaseEnd = (phaseCnt == CNT_LAST);

  // control register: forced reset beats a software write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlReg   <= 2'b11;
      engClear <= 1'b0;
    end else begin
      engClear <= rstCmd;
      if (rstCmd)
        ctlReg <= 2'b01;
      else if (ctlWrEn)
        ctlReg <= ctlWrData;
    end
  end

  // automatic pulse generator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= AR_IDLE;
      phaseCnt <= '0;
      pulseCnt <= '0;
    end else if (rstCmd) begin
      state    <= AR_IDLE;
      phaseCnt <= '0;
      pulseCnt <= '0;
    end else begin
      case (state)
        AR_IDLE: begin
          phaseCnt <= '0;
          pulseCnt <= '0;
          if (goOk && !sdaSync) state <= AR_LOW;
        end
        AR_LOW: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            state    <= AR_HIGH;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        AR_HIGH: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            pulseCnt <= pulseCnt + 1'b1;
            if (sdaSync || (pulseCnt == PULSE_LAST))
              state <= AR_IDLE;
            else
              state <= AR_LOW;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= AR_IDLE;
      endcase
    end
  end

  assign autoBusy       = (state != AR_IDLE);
  assign lineCtl.engOwn = (ctlReg == 2'b11) && !autoBusy;
  assign lineCtl.sclRel = autoBusy ? (state == AR_HIGH) : ctlReg[0];
  assign ctlRd          = ctlReg;
endmodule

// File: rtl/busrec_dp.sv
module busrec_dp
  import busrec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  lineCtl_t   lineCtl,
  input  logic       engSclDrive,
  input  logic       engSdaDrive,
  input  logic       sclPadIn,
  input  logic       sdaPadIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic [3:0] monData,
  output logic       sdaSync
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sclFf;
  logic [LAST:0] sdaFf;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclFf[gi] <= 1'b1;
          sdaFf[gi] <= 1'b1;
        end else if (gi == 0) begin
          sclFf[gi] <= sclPadIn;
          sdaFf[gi] <= sdaPadIn;
        end else begin
          sclFf[gi] <= sclFf[(gi > 0) ? gi - 1 : 0];
          sdaFf[gi] <= sdaFf[(gi > 0) ? gi - 1 : 0];
        end
      end
    end
  endgenerate

  always_comb begin
    if (lineCtl.engOwn) begin
      sclOe = !engSclDrive;
      sdaOe = !engSdaDrive;
    end else begin
      sclOe = !lineCtl.sclRel;
      sdaOe = 1'b0;
    end
  end

  assign sdaSync = sdaFf[LAST];
  assign monData = {!sdaOe, sdaFf[LAST], !sclOe, sclFf[LAST]};
endmodule

// File: rtl/busrec_unit.sv
module busrec_unit
  import busrec_pkg::*;
#(
  parameter int HALF_CYC    = 4,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic [1:0] ctlWrData,
  input  logic       rstCmd,
  input  logic       autoGo,
  input  logic       engSclDrive,
  input  logic       engSdaDrive,
  input  logic       sclPadIn,
  input  logic       sdaPadIn,
  output logic       sclOe,
  output logic       sdaOe,
  output logic [3:0] monData,
  output logic [1:0] ctlRd,
  output logic       engClear,
  output logic       autoBusy
);
  lineCtl_t lineCtl;
  logic     sdaSync;

  busrec_ctl #(.HALF_CYC(HALF_CYC), .MAX_PULSES(MAX_PULSES)) uCtl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .rstCmd(rstCmd), .autoGo(autoGo), .sdaSync(sdaSync), .lineCtl(lineCtl),
    .ctlRd(ctlRd), .engClear(engClear), .autoBusy(autoBusy)
  );

  busrec_dp #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .lineCtl(lineCtl), .engSclDrive(engSclDrive),
    .engSdaDrive(engSdaDrive), .sclPadIn(sclPadIn), .sdaPadIn(sdaPadIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .monData(monData), .sdaSync(sdaSync)
  );
endmodule

// File: rtl/busrec_chk.sv
module busrec_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       rstCmd,
  input logic       engSclDrive,
  input logic       engSdaDrive,
  input logic       sclPadIn,
  input logic       sdaPadIn,
  input logic       sclOe,
  input logic       sdaOe,
  input logic [3:0] monData,
  input logic [1:0] ctlRd,
  input logic       engClear,
  input logic       autoBusy
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam int SW = $clog2(SYNC_STAGES + 1);

  logic [LAST:0] sclHist;
  logic [LAST:0] sdaHist;
  logic [SW-1:0] seen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclHist <= '1;
      sdaHist <= '1;
      seen    <= '0;
    end else begin
      sclHist <= {sclHist[LAST:0], sclPadIn} >> 0;
      sdaHist <= {sdaHist[LAST:0], sdaPadIn} >> 0;
      if (seen != SW'(SYNC_STAGES)) seen <= seen + 1'b1;
    end
  end

  assert_sda_free_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRd != 2'b11) |-> !sdaOe);

  assert_engine_path_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlRd == 2'b11 && !autoBusy) |-> (sclOe == !engSclDrive && sdaOe == !engSdaDrive));

  assert_scl_forced_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctlRd[0] && !autoBusy) |-> sclOe);

  assert_mon_drive_R6: assert property (@(posedge clk) disable iff (!rstN)
    (monData[3] == !sdaOe) && (monData[1] == !sclOe));

  assert_sync_delay_R7: assert property (@(posedge clk) disable iff (!rstN)
    (seen == SW'(SYNC_STAGES)) |-> (monData[0] == sclHist[LAST] && monData[2] == sdaHist[LAST]));

  assert_clear_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    rstCmd |=> (engClear && ctlRd == 2'b01 && !autoBusy));

  assert_start_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(autoBusy) |-> $past(!ctlRd[1]));

  assert_sda_idle_auto_R13: assert property (@(posedge clk) disable iff (!rstN)
    autoBusy |-> !sdaOe);
endmodule

bind busrec_unit busrec_chk #(.SYNC_STAGES(SYNC_STAGES)) uChk (
  .clk(clk), .rstN(rstN), .rstCmd(rstCmd), .engSclDrive(engSclDrive),
  .engSdaDrive(engSdaDrive), .sclPadIn(sclPadIn), .sdaPadIn(sdaPadIn),
  .sclOe(sclOe), .sdaOe(sdaOe), .monData(monData), .ctlRd(ctlRd),
  .engClear(engClear), .autoBusy(autoBusy)
);

// File: tb/sim_busrec_unit.sv
module sim_busrec_unit;
  localparam int HALF = 4;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctlWrEn = 1'b0;
  logic [1:0] ctlWrData = 2'b00;
  logic rstCmd = 1'b0;
  logic autoGo = 1'b0;
  logic engSclDrive = 1'b1;
  logic engSdaDrive = 1'b1;
  logic sclPadIn, sdaPadIn;
  logic sclOe, sdaOe;
  logic [3:0] monData;
  logic [1:0] ctlRd;
  logic engClear, autoBusy;

  logic useWire = 1'b0;
  logic holdArmed = 1'b0;
  logic rndScl = 1'b1;
  logic rndSda = 1'b1;
  logic clrRises = 1'b0;
  logic prevScl = 1'b1;
  int   releaseAt = 0;
  int   risesSeen = 0;
  logic slaveHold;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign slaveHold = holdArmed && (risesSeen < releaseAt);
  assign sclPadIn  = useWire ? !sclOe : rndScl;
  assign sdaPadIn  = useWire ? (!sdaOe && !slaveHold) : rndSda;

  always @(posedge clk) begin
    prevScl <= sclPadIn;
    if (clrRises) risesSeen <= 0;
    else if (sclPadIn && !prevScl) risesSeen <= risesSeen + 1;
  end

  busrec_unit #(.HALF_CYC(HALF), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .rstCmd(rstCmd), .autoGo(autoGo), .engSclDrive(engSclDrive),
    .engSdaDrive(engSdaDrive), .sclPadIn(sclPadIn), .sdaPadIn(sdaPadIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .monData(monData), .ctlRd(ctlRd),
    .engClear(engClear), .autoBusy(autoBusy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wr_ctl(input logic [1:0] v);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  function automatic bit exp_scl_oe(input logic [1:0] m, input logic e);
    return (m == 2'b11) ? !e : !m[0];
  endfunction

  function automatic bit exp_sda_oe(input logic [1:0] m, input logic e);
    return (m == 2'b11) ? !e : 1'b0;
  endfunction

  // run a recovery and report rises and low-phase cycles
  task automatic run_auto(output int rises, output int lowCyc, output bit sdaDrove);
    int guard;
    lowCyc = 0; sdaDrove = 0; guard = 0;
    @(negedge clk);
    autoGo = 1'b1;
    @(negedge clk);
    autoGo = 1'b0;
    while (autoBusy && guard < 1000) begin
      if (sclOe) lowCyc++;
      if (sdaOe) sdaDrove = 1;
      guard++;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    rises = risesSeen;
  endtask

  initial begin
    int rises, lowCyc;
    bit sdaDrove;
    logic [1:0] model;
    logic h1Scl, h2Scl, h1Sda, h2Sda;
    logic pendClr;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctlRd == 2'b11, "R1 ctl", ctlRd, 3);
    chk(!engClear && !autoBusy, "R1 flags", {engClear, autoBusy}, 0);
    chk(monData[2] && monData[0], "R1 mon", monData, 4'hF);

    // random phase over control values, engine requests and pad levels
    model = 2'b11; pendClr = 0;
    h1Scl = rndScl; h2Scl = rndScl; h1Sda = rndSda; h2Sda = rndSda;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      #1;
      chk(ctlRd == model, "R8 ctl model", ctlRd, model);
      chk(engClear == pendClr, "R8 clear pulse", engClear, pendClr);
      chk(sclOe == exp_scl_oe(model, engSclDrive),
          (model == 2'b11) ? "R2 scl" : (model[0] ? "R5 scl" : "R4 scl"),
          sclOe, exp_scl_oe(model, engSclDrive));
      chk(sdaOe == exp_sda_oe(model, engSdaDrive),
          (model == 2'b11) ? "R2 sda" : "R3 sda", sdaOe, exp_sda_oe(model, engSdaDrive));
      chk(monData[3] == !sdaOe && monData[1] == !sclOe, "R6 driven bits", monData, {!sdaOe, 1'b0, !sclOe, 1'b0});
      if (i >= 2) begin
        chk(monData[0] == h2Scl, "R7 scl sample", monData[0], h2Scl);
        chk(monData[2] == h2Sda, "R7 sda sample", monData[2], h2Sda);
      end
      h2Scl = h1Scl; h2Sda = h1Sda;
      rndScl = 1'($urandom); rndSda = 1'($urandom);
      h1Scl = rndScl; h1Sda = rndSda;
      engSclDrive = 1'($urandom); engSdaDrive = 1'($urandom);
      ctlWrEn = ($urandom % 3) == 0;
      ctlWrData = 2'($urandom);
      rstCmd = ($urandom % 16) == 0;
      pendClr = rstCmd;
      if (rstCmd) model = 2'b01;
      else if (ctlWrEn) model = ctlWrData;
    end
    @(negedge clk);
    ctlWrEn = 1'b0; rstCmd = 1'b0;
    engSclDrive = 1'b1; engSdaDrive = 1'b1;

    // directed: wired bus with a stuck slave
    useWire = 1'b1;
    rndScl = 1'b1; rndSda = 1'b1;
    wr_ctl(2'b01);
    holdArmed = 1'b1; releaseAt = 3;
    clrRises = 1'b1; @(negedge clk); clrRises = 1'b0;
    repeat (4) @(negedge clk);
    chk(monData[2] == 1'b0, "R7 stuck sda seen", monData[2], 0);
    run_auto(rises, lowCyc, sdaDrove);
    chk(rises == 3, "R11 pulses until release", rises, 3);
    chk(lowCyc == 3 * HALF, "R11 low phase cycles", lowCyc, 3 * HALF);
    chk(!sclOe, "R11 scl released at end", sclOe, 0);
    chk(monData[2] == 1'b1, "R11 sda freed", monData[2], 1);
    chk(!sdaDrove, "R13 sda released during run", sdaDrove, 0);

    // cap on pulse count
    holdArmed = 1'b1; releaseAt = 1000;
    clrRises = 1'b1; @(negedge clk); clrRises = 1'b0;
    repeat (4) @(negedge clk);
    run_auto(rises, lowCyc, sdaDrove);
    chk(rises == MAXP, "R12 pulse cap", rises, MAXP);
    chk(lowCyc == MAXP * HALF, "R12 low cycles", lowCyc, MAXP * HALF);
    chk(!autoBusy && !sclOe, "R12 stopped released", {autoBusy, sclOe}, 0);

    // SDA already high: no pulses
    holdArmed = 1'b0;
    clrRises = 1'b1; @(negedge clk); clrRises = 1'b0;
    repeat (4) @(negedge clk);
    run_auto(rises, lowCyc, sdaDrove);
    chk(rises == 0 && lowCyc == 0, "R10 no pulse when sda high", rises, 0);

    // autoGo while engine owns the bus is ignored
    wr_ctl(2'b11);
    holdArmed = 1'b1; releaseAt = 1000;
    clrRises = 1'b1; @(negedge clk); clrRises = 1'b0;
    repeat (4) @(negedge clk);
    run_auto(rises, lowCyc, sdaDrove);
    chk(rises == 0 && !autoBusy, "R9 start ignored in normal op", rises, 0);
    chk(sclOe == !engSclDrive, "R9 engine keeps scl", sclOe, !engSclDrive);

    // forced reset aborts a run
    wr_ctl(2'b00);
    repeat (4) @(negedge clk);
    autoGo = 1'b1; @(negedge clk); autoGo = 1'b0;
    repeat (5) @(negedge clk);
    chk(autoBusy, "R9 start accepted with bit1 clear", autoBusy, 1);
    rstCmd = 1'b1; ctlWrEn = 1'b1; ctlWrData = 2'b10;
    @(negedge clk);
    rstCmd = 1'b0; ctlWrEn = 1'b0;
    #1;
    chk(engClear && !autoBusy, "R8 abort and clear", {engClear, autoBusy}, 2);
    chk(ctlRd == 2'b01, "R8 priority over write", ctlRd, 1);
    chk(!sclOe && !sdaOe, "R8 lines released", {sclOe, sdaOe}, 0);
    @(negedge clk);
    chk(!engClear, "R8 single pulse", engClear, 0);

    holdArmed = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule